// File: doc/BRIEF.md
# Pixel Format Converting Downscaler

This block takes one image as a stream of bytes and sends it back out as a stream of bytes. On the way it can change the packed colour format, halve the image size with a box filter, and turn the image upside down. Five packed formats are supported: 32-bit and 24-bit true colour, and three 16-bit layouts. The 16-bit layouts are 5-6-5, 5-5-5 with one alpha bit, and 4-4-4-4. The scaler can halve the width only, or both the width and the height. A raw copy setting sends the input bytes out unchanged.

A frame begins with a one-cycle `start` pulse. On that pulse the block latches the size, the two formats, the scaling mode, the flip flag and the copy flag. It then accepts exactly width × height × (input bytes per pixel) bytes through a valid/ready handshake. In the converting modes the whole frame is first decoded into an internal 8-bit-per-channel store, which holds up to `MAX_PIX` pixels. The output pixels are then read back in the order that flipping and scaling require, and each one is packed into the output format. In copy mode the bytes pass straight from input to output. The caller must keep width × height at or below `MAX_PIX` for the converting modes, and must keep both width and height at one or more.

Top module: `pix_convert_scaler`

## Requirements
- R1: Out of reset, and at any time no frame is in progress, `busy`, `in_ready` and `out_valid` are low, so input bytes offered while idle are not taken.
- R2: Format codes are 0 = 32-bit RGBA (4 bytes), 1 = 24-bit RGB (3 bytes), 2 = 5-6-5 RGB (2 bytes), 3 = 5-5-5 RGB plus a 1-bit alpha in bit 0 (2 bytes) and 4 = 4-4-4-4 RGBA (2 bytes). In every format red sits in the most significant field and the fields run red, green, blue, alpha downwards. The bytes of a pixel word travel least significant byte first, on both input and output.
- R3: A field narrower than 8 bits is widened by repeating its top bits below it, so a 1-bit alpha becomes 0x00 or 0xFF. A format that has no alpha field reads as alpha 0xFF.
- R4: When a field is narrowed for output, its low bits are dropped.
- R5: Scaling modes 0 and 3 keep the input size. Each output pixel is the converted input pixel at the same place, in raster order.
- R6: Scaling mode 1 gives an output width of floor(width/2) and keeps the height. Each channel is (a+b+1)>>1 of the 8-bit channels of the horizontal pair, and an odd last column is dropped.
- R7: Scaling mode 2 halves the width and the height, rounding each down. Each channel is (s+2)>>2 of the sum of the 2×2 block, and an odd last row or column is dropped.
- R8: With flip set, row r is taken from input row height-1-r before any scaling is applied.
- R9: With copy set, exactly width × height × (input bytes per pixel) bytes leave unchanged and in order. The output format and the scaling mode are ignored.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. Back-pressure and gaps in the input lose no byte and add none.
- R11: In the converting modes no output byte appears before the whole frame is taken in, and no input is taken while the output is being sent. A `start` pulse, or a change on the configuration inputs, while `busy` is high has no effect. `busy` falls after the last output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a frame when idle; latches configuration |
| cfg_width | input | 9 | Input width in pixels, 1..256 |
| cfg_height | input | 11 | Input height in rows, 1 or more |
| cfg_in_fmt | input | 3 | Input format code |
| cfg_out_fmt | input | 3 | Output format code |
| cfg_scale | input | 2 | Scaling mode 0..3 |
| cfg_flip | input | 1 | Reverse row order |
| cfg_copy | input | 1 | Raw byte pass-through |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Sink accepts output byte |
| busy | output | 1 | A frame is in progress |

## Verification
All 25 pairings of input and output format are run on an unscaled 3×2 frame with varied pixel bytes. A wrong field position, a wrong widening, alpha handling or byte order shows up as a corrupted output byte.

Odd widths and heights are run in both halving modes with and without flip, and a 256-pixel-wide frame is added. These show the rounding, the dropped edge column or row, and whether rows are reversed before or after averaging.

Copy frames over every input format check the byte count and the ignored output format. Every frame runs under irregular input gaps, irregular output back-pressure, and a second `start` with junk configuration issued mid-frame.

// File: rtl/pcs_pkg.sv
// Shared constants and pixel packing functions for the converting scaler.
// Internal pixels are {red, green, blue, alpha}, 8 bits each, red in [31:24].
// Unknown format codes are handled as the 32-bit RGBA layout.
package pcs_pkg;

    localparam logic [2:0] PF_RGBA8  = 3'd0;
    localparam logic [2:0] PF_RGB8   = 3'd1;
    localparam logic [2:0] PF_RGB565 = 3'd2;
    localparam logic [2:0] PF_RGB5A1 = 3'd3;
    localparam logic [2:0] PF_RGBA4  = 3'd4;

    localparam logic [1:0] SC_NONE = 2'd0;
    localparam logic [1:0] SC_X    = 2'd1;
    localparam logic [1:0] SC_XY   = 2'd2;

    // Bytes occupied by one pixel of the given format.
    function automatic logic [2:0] pcs_bytes(input logic [2:0] fmt);
        case (fmt)
            PF_RGB8:                        return 3'd3;
            PF_RGB565, PF_RGB5A1, PF_RGBA4: return 3'd2;
            default:                        return 3'd4;
        endcase
    endfunction

    // Expand a packed word into 8-bit channels (bit replication, opaque default alpha).
    function automatic logic [31:0] pcs_decode(input logic [31:0] raw, input logic [2:0] fmt);
        logic [7:0] r, g, b, a;
        case (fmt)
            PF_RGB8: begin
                r = raw[23:16]; g = raw[15:8]; b = raw[7:0]; a = 8'hFF;
            end
            PF_RGB565: begin
                r = {raw[15:11], raw[15:13]};
                g = {raw[10:5], raw[10:9]};
                b = {raw[4:0], raw[4:2]};
                a = 8'hFF;
            end
            PF_RGB5A1: begin
                r = {raw[15:11], raw[15:13]};
                g = {raw[10:6], raw[10:8]};
                b = {raw[5:1], raw[5:3]};
                a = {8{raw[0]}};
            end
            PF_RGBA4: begin
                r = {2{raw[15:12]}};
                g = {2{raw[11:8]}};
                b = {2{raw[7:4]}};
                a = {2{raw[3:0]}};
            end
            default: begin
                r = raw[31:24]; g = raw[23:16]; b = raw[15:8]; a = raw[7:0];
            end
        endcase
        return {r, g, b, a};
    endfunction

    // Pack 8-bit channels into the given format, truncating low bits.
    function automatic logic [31:0] pcs_encode(input logic [31:0] px, input logic [2:0] fmt);
        logic [7:0] r, g, b, a;
        r = px[31:24]; g = px[23:16]; b = px[15:8]; a = px[7:0];
        case (fmt)
            PF_RGB8:   return {8'h00, r, g, b};
            PF_RGB565: return {16'h0000, r[7:3], g[7:2], b[7:3]};
            PF_RGB5A1: return {16'h0000, r[7:3], g[7:3], b[7:3], a[7]};
            PF_RGBA4:  return {16'h0000, r[7:4], g[7:4], b[7:4], a[7:4]};
            default:   return px;
        endcase
    endfunction

endpackage

// File: rtl/pcs_unpack.sv
// Gathers input bytes into one pixel word (least significant byte first)
// and decodes it to 8-bit channels. Assumes fmt is steady for a whole frame
// and that clear is held while no frame is loading.
module pcs_unpack
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic [2:0]  fmt,
    input  logic [7:0]  byte_in,
    input  logic        byte_en,
    output logic        last_byte,
    output logic        pix_valid,
    output logic [31:0] pix_rgba
);

    logic [1:0]  cnt;
    logic [23:0] held;
    logic [31:0] raw;

    // Flag the byte that completes the current pixel.
    always_comb begin
        last_byte = ({1'b0, cnt} == (pcs_bytes(fmt) - 3'd1));
    end

    // Merge the incoming byte into the partial word at its byte slot.
    always_comb begin
        raw = (cnt == 2'd0) ? 32'h0 : {8'h00, held};
        raw[8*cnt +: 8] = byte_in;
    end

    // Advance the byte slot and emit a decoded pixel on its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt       <= 2'd0;
            held      <= 24'h0;
            pix_valid <= 1'b0;
            pix_rgba  <= 32'h0;
        end else begin
            pix_valid <= byte_en && last_byte;
            if (byte_en) begin
                if (last_byte) begin
                    cnt      <= 2'd0;
                    pix_rgba <= pcs_decode(raw, fmt);
                end else begin
                    cnt  <= cnt + 2'd1;
                    held <= raw[23:0];
                end
            end
        end
    end

endmodule

// File: rtl/pcs_fbuf.sv
// Single-write, single-read pixel store with a registered read port.
// Read data appears the cycle after the address is presented. No reset on contents.
module pcs_fbuf #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] mem [DEPTH];

    // Write one pixel and read one pixel per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/pcs_reader.sv
// Walks the output raster and fetches 1, 2 or 4 stored samples per output
// pixel, with the row index mirrored when flip is set, then hands out the
// rounded mean. Each sample costs two cycles: address, then accumulate.
// Assumes the configuration inputs stay steady while busy.
module pcs_reader
    import pcs_pkg::*;
#(
    parameter int WB = 9,
    parameter int HB = 11,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WB-1:0] width,
    input  logic [HB-1:0] height,
    input  logic [1:0]    scale,
    input  logic          flip,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output logic          pix_valid,
    output logic [31:0]   pix_data,
    input  logic          pix_ready,
    output logic          busy
);

    localparam logic [HB-1:0] H_ONE = 1;
    localparam logic [WB-1:0] W_ONE = 1;

    typedef enum logic [1:0] {RS_IDLE, RS_ADDR, RS_DATA, RS_OUT} rs_e;

    rs_e           state;
    logic [WB-1:0] ox;
    logic [HB-1:0] oy;
    logic [1:0]    k;
    logic [9:0]    acc [4];

    logic [1:0]    eff;
    logic [WB-1:0] out_w;
    logic [HB-1:0] out_h;
    logic          k_last;
    logic [WB-1:0] sx;
    logic [HB-1:0] fy;
    logic [HB-1:0] src_row;

    // Effective mode and output dimensions (mode 3 behaves as mode 0).
    always_comb begin
        eff   = (scale == 2'd3) ? SC_NONE : scale;
        out_w = (eff == SC_NONE) ? width : (width >> 1);
        out_h = (eff == SC_XY) ? (height >> 1) : height;
        case (eff)
            SC_NONE: k_last = (k == 2'd0);
            SC_X:    k_last = (k == 2'd1);
            default: k_last = (k == 2'd3);
        endcase
    end

    // Sample coordinates and store address of the current sample.
    always_comb begin
        sx      = (eff == SC_NONE) ? ox : {ox[WB-2:0], k[0]};
        fy      = (eff == SC_XY) ? {oy[HB-2:0], k[1]} : oy;
        src_row = flip ? (height - H_ONE - fy) : fy;
        rd_addr = AW'(src_row) * AW'(width) + AW'(sx);
    end

    // Output pixel rounding, one lane per channel.
    for (genvar i = 0; i < 4; i++) begin : g_lane
        logic [7:0] avg;
        always_comb begin
            case (eff)
                SC_X:    avg = 8'((acc[i] + 10'd1) >> 1);
                SC_XY:   avg = 8'((acc[i] + 10'd2) >> 2);
                default: avg = acc[i][7:0];
            endcase
        end
        assign pix_data[8*(3-i) +: 8] = avg;
    end

    assign pix_valid = (state == RS_OUT);
    assign busy      = (state != RS_IDLE);

    // Sequence sample fetches and raster position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            ox    <= '0;
            oy    <= '0;
            k     <= 2'd0;
            for (int i = 0; i < 4; i++) acc[i] <= 10'd0;
        end else begin
            case (state)
                RS_IDLE: begin
                    if (start && (out_w != '0) && (out_h != '0)) begin
                        ox    <= '0;
                        oy    <= '0;
                        k     <= 2'd0;
                        state <= RS_ADDR;
                    end
                end
                RS_ADDR: state <= RS_DATA;
                RS_DATA: begin
                    for (int i = 0; i < 4; i++) begin
                        acc[i] <= ((k == 2'd0) ? 10'd0 : acc[i]) + {2'b00, rd_data[8*(3-i) +: 8]};
                    end
                    if (k_last) begin
                        state <= RS_OUT;
                    end else begin
                        k     <= k + 2'd1;
                        state <= RS_ADDR;
                    end
                end
                default: begin
                    if (pix_ready) begin
                        k <= 2'd0;
                        if (ox == out_w - W_ONE) begin
                            ox <= '0;
                            if (oy == out_h - H_ONE) begin
                                state <= RS_IDLE;
                            end else begin
                                oy    <= oy + H_ONE;
                                state <= RS_ADDR;
                            end
                        end else begin
                            ox    <= ox + W_ONE;
                            state <= RS_ADDR;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pcs_pack.sv
// Encodes one pixel into the output format and serialises its bytes, least
// significant first, over a valid/ready handshake. Takes a new pixel only when empty.
module pcs_pack
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  fmt,
    input  logic        pix_valid,
    input  logic [31:0] pix_data,
    output logic        pix_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    output logic        busy
);

    logic        full;
    logic [1:0]  idx;
    logic [31:0] word;

    assign pix_ready = !full;
    assign out_valid = full;
    assign busy      = full;
    assign out_data  = word[8*idx +: 8];

    // Load an encoded pixel, then step through its bytes as they are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            idx  <= 2'd0;
            word <= 32'h0;
        end else if (!full) begin
            if (pix_valid) begin
                word <= pcs_encode(pix_data, fmt);
                idx  <= 2'd0;
                full <= 1'b1;
            end
        end else if (out_ready) begin
            if ({1'b0, idx} == (pcs_bytes(fmt) - 3'd1)) begin
                full <= 1'b0;
            end else begin
                idx <= idx + 2'd1;
            end
        end
    end

endmodule

// File: rtl/pix_convert_scaler.sv
// Top level: frame control, raw-copy bypass, and the load / emit pipeline.
// A converting frame is loaded whole into the pixel store, then read out
// flipped and scaled. Assumes width, height >= 1 and width*height <= MAX_PIX
// for converting frames.
module pix_convert_scaler
    import pcs_pkg::*;
#(
    parameter int MAX_W   = 256,
    parameter int MAX_PIX = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [8:0]  cfg_width,
    input  logic [10:0] cfg_height,
    input  logic [2:0]  cfg_in_fmt,
    input  logic [2:0]  cfg_out_fmt,
    input  logic [1:0]  cfg_scale,
    input  logic        cfg_flip,
    input  logic        cfg_copy,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        busy
);

    localparam int WB = $clog2(MAX_W + 1);
    localparam int HB = $clog2(MAX_PIX + 1);
    localparam int AW = $clog2(MAX_PIX);
    localparam int PB = WB + HB;
    localparam int CB = PB + 2;
    localparam logic [PB-1:0] P_ONE = 1;
    localparam logic [CB-1:0] C_ONE = 1;

    typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_LOAD, ST_EMIT} st_e;

    st_e           state;
    logic [WB-1:0] c_w;
    logic [HB-1:0] c_h;
    logic [2:0]    c_in, c_out;
    logic [1:0]    c_scale;
    logic          c_flip;

    logic [PB-1:0] npix;
    logic [CB-1:0] copy_total;
    logic [PB-1:0] in_pix;
    logic [PB-1:0] wr_cnt;
    logic [CB-1:0] byte_cnt;
    logic          in_done;
    logic          rd_start;

    logic          in_load_phase, in_emit_phase, in_copy_phase;
    logic          load_take, copy_take;

    logic          up_last, up_valid;
    logic [31:0]   up_rgba;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic          rd_pix_valid, rd_pix_ready, rd_busy;
    logic [31:0]   rd_pix;
    logic          pk_valid, pk_busy;
    logic [7:0]    pk_data;

    // Frame size products from the latched configuration.
    always_comb begin
        npix       = PB'(c_w) * PB'(c_h);
        copy_total = CB'(npix) * CB'(pcs_bytes(c_in));
    end

    // Phase decode and handshake steering between copy and converting paths.
    always_comb begin
        in_load_phase = (state == ST_LOAD);
        in_emit_phase = (state == ST_EMIT);
        in_copy_phase = (state == ST_COPY);
        load_take     = in_load_phase && !in_done && in_valid;
        copy_take     = in_copy_phase && in_valid && out_ready;
        in_ready      = in_copy_phase ? out_ready : (in_load_phase && !in_done);
        out_valid     = in_copy_phase ? in_valid : pk_valid;
        out_data      = in_copy_phase ? in_data : pk_data;
        busy          = (state != ST_IDLE);
    end

    // Frame state machine, configuration latch and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            c_w      <= '0;
            c_h      <= '0;
            c_in     <= PF_RGBA8;
            c_out    <= PF_RGBA8;
            c_scale  <= SC_NONE;
            c_flip   <= 1'b0;
            in_pix   <= '0;
            wr_cnt   <= '0;
            byte_cnt <= '0;
            in_done  <= 1'b0;
            rd_start <= 1'b0;
        end else begin
            rd_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        c_w      <= cfg_width;
                        c_h      <= cfg_height;
                        c_in     <= cfg_in_fmt;
                        c_out    <= cfg_out_fmt;
                        c_scale  <= cfg_scale;
                        c_flip   <= cfg_flip;
                        in_pix   <= '0;
                        wr_cnt   <= '0;
                        byte_cnt <= '0;
                        in_done  <= 1'b0;
                        state    <= cfg_copy ? ST_COPY : ST_LOAD;
                    end
                end
                ST_COPY: begin
                    if (copy_take) begin
                        if (byte_cnt == copy_total - C_ONE) begin
                            state <= ST_IDLE;
                        end else begin
                            byte_cnt <= byte_cnt + C_ONE;
                        end
                    end
                end
                ST_LOAD: begin
                    if (load_take && up_last) begin
                        in_pix <= in_pix + P_ONE;
                        if (in_pix == npix - P_ONE) in_done <= 1'b1;
                    end
                    if (up_valid) begin
                        wr_cnt <= wr_cnt + P_ONE;
                        if (wr_cnt == npix - P_ONE) begin
                            state    <= ST_EMIT;
                            rd_start <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (!rd_start && !rd_busy && !pk_busy) state <= ST_IDLE;
                end
            endcase
        end
    end

    pcs_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_IDLE),
        .fmt       (c_in),
        .byte_in   (in_data),
        .byte_en   (load_take),
        .last_byte (up_last),
        .pix_valid (up_valid),
        .pix_rgba  (up_rgba)
    );

    pcs_fbuf #(.DEPTH(MAX_PIX), .AW(AW)) u_fbuf (
        .clk   (clk),
        .we    (up_valid),
        .waddr (wr_cnt[AW-1:0]),
        .wdata (up_rgba),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    pcs_reader #(.WB(WB), .HB(HB), .AW(AW)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_start),
        .width     (c_w),
        .height    (c_h),
        .scale     (c_scale),
        .flip      (c_flip),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .pix_valid (rd_pix_valid),
        .pix_data  (rd_pix),
        .pix_ready (rd_pix_ready),
        .busy      (rd_busy)
    );

    pcs_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (c_out),
        .pix_valid (rd_pix_valid),
        .pix_data  (rd_pix),
        .pix_ready (rd_pix_ready),
        .out_valid (pk_valid),
        .out_data  (pk_data),
        .out_ready (out_ready && in_emit_phase),
        .busy      (pk_busy)
    );

endmodule

// File: rtl/pcs_checks.sv
// Protocol and phase checks for the converting scaler, bound to the top.
module pcs_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       loading,
    input logic       emitting
);

    // Idle means neither side of the stream moves.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid));

    // A stalled output byte stays put in the converting path.
    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (emitting && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // Nothing leaves while the frame is still loading.
    assert_load_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !out_valid);

    // No input is taken while output is being produced.
    assert_emit_no_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
        emitting |-> !in_ready);

    // Output is only offered inside a frame.
    assert_valid_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

endmodule

bind pix_convert_scaler pcs_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .loading   (in_load_phase),
    .emitting  (in_emit_phase)
);

// File: tb/pix_convert_scaler_bench.sv
// Sweeps formats, scaling modes, flip and copy on small frames; expected
// bytes come from an arithmetic model of the requirements.
module pix_convert_scaler_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  cfg_width = '0;
    logic [10:0] cfg_height = '0;
    logic [2:0]  cfg_in_fmt = '0;
    logic [2:0]  cfg_out_fmt = '0;
    logic [1:0]  cfg_scale = '0;
    logic        cfg_flip = 1'b0;
    logic        cfg_copy = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] src_b [0:2047];
    logic [7:0] exp_b [0:2047];
    int         n_exp;
    int         n_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_convert_scaler u_pix_convert_scaler (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_in_fmt(cfg_in_fmt), .cfg_out_fmt(cfg_out_fmt),
        .cfg_scale(cfg_scale), .cfg_flip(cfg_flip), .cfg_copy(cfg_copy),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int bpp_of(input int f);
        if (f == 1) return 3;
        if (f >= 2 && f <= 4) return 2;
        return 4;
    endfunction

    // Channels of the source pixel at column x of flipped-view row fy (R2, R3, R8).
    task automatic src_pix(input int w, input int h, input int f, input int flip,
                           input int x, input int fy, output int c [4]);
        int row, base, v, nb;
        row  = flip ? (h - 1 - fy) : fy;
        nb   = bpp_of(f);
        base = (row * w + x) * nb;
        v = 0;
        for (int i = 0; i < nb; i++) v = v | (int'(src_b[base + i]) << (8 * i));
        case (f)
            1: begin c[0] = (v >> 16) & 255; c[1] = (v >> 8) & 255; c[2] = v & 255; c[3] = 255; end
            2: begin
                c[0] = (((v >> 11) & 31) << 3) | (((v >> 11) & 31) >> 2);
                c[1] = (((v >> 5) & 63) << 2) | (((v >> 5) & 63) >> 4);
                c[2] = ((v & 31) << 3) | ((v & 31) >> 2);
                c[3] = 255;
            end
            3: begin
                c[0] = (((v >> 11) & 31) << 3) | (((v >> 11) & 31) >> 2);
                c[1] = (((v >> 6) & 31) << 3) | (((v >> 6) & 31) >> 2);
                c[2] = (((v >> 1) & 31) << 3) | (((v >> 1) & 31) >> 2);
                c[3] = (v & 1) ? 255 : 0;
            end
            4: begin
                c[0] = ((v >> 12) & 15) * 17; c[1] = ((v >> 8) & 15) * 17;
                c[2] = ((v >> 4) & 15) * 17;  c[3] = (v & 15) * 17;
            end
            default: begin
                c[0] = (v >> 24) & 255; c[1] = (v >> 16) & 255;
                c[2] = (v >> 8) & 255;  c[3] = v & 255;
            end
        endcase
    endtask

    // Pack channels into output bytes, dropping low bits (R4).
    task automatic push_pix(input int f, input int c [4]);
        int v;
        case (f)
            1: v = (c[0] << 16) | (c[1] << 8) | c[2];
            2: v = ((c[0] >> 3) << 11) | ((c[1] >> 2) << 5) | (c[2] >> 3);
            3: v = ((c[0] >> 3) << 11) | ((c[1] >> 3) << 6) | ((c[2] >> 3) << 1) | (c[3] >> 7);
            4: v = ((c[0] >> 4) << 12) | ((c[1] >> 4) << 8) | ((c[2] >> 4) << 4) | (c[3] >> 4);
            default: v = (c[0] << 24) | (c[1] << 16) | (c[2] << 8) | c[3];
        endcase
        for (int i = 0; i < bpp_of(f); i++) begin
            exp_b[n_exp] = 8'((v >> (8 * i)) & 255);
            n_exp++;
        end
    endtask

    // Expected output stream for one frame (R5, R6, R7, R8, R9).
    task automatic build_expected(input int w, input int h, input int inf, input int outf,
                                  input int sc, input int flip, input int cp);
        int eff, ow, oh, ns;
        int s [4];
        int c [4];
        int o [4];
        n_exp = 0;
        if (cp != 0) begin
            for (int i = 0; i < n_src; i++) exp_b[i] = src_b[i];
            n_exp = n_src;
            return;
        end
        eff = (sc == 3) ? 0 : sc;
        ow  = (eff == 0) ? w : w / 2;
        oh  = (eff == 2) ? h / 2 : h;
        ns  = (eff == 0) ? 1 : (eff == 1) ? 2 : 4;
        for (int oy = 0; oy < oh; oy++) begin
            for (int ox = 0; ox < ow; ox++) begin
                for (int j = 0; j < 4; j++) s[j] = 0;
                for (int k = 0; k < ns; k++) begin
                    int sx, sy;
                    sx = (eff == 0) ? ox : 2 * ox + (k % 2);
                    sy = (eff == 2) ? 2 * oy + (k / 2) : oy;
                    src_pix(w, h, inf, flip, sx, sy, c);
                    for (int j = 0; j < 4; j++) s[j] += c[j];
                end
                for (int j = 0; j < 4; j++) o[j] = (s[j] + ns / 2) / ns;
                push_pix(outf, o);
            end
        end
    endtask

    // Run one frame under gaps and back-pressure, with a mid-frame restart attempt (R10, R11).
    task automatic run_frame(input int w, input int h, input int inf, input int outf,
                             input int sc, input int flip, input int cp, input int seed,
                             input string req);
        int got, extra, guard;
        n_src = w * h * bpp_of(inf);
        for (int i = 0; i < n_src; i++) src_b[i] = 8'(((i * 37) + (seed * 29) + 11) ^ (i >> 3));
        build_expected(w, h, inf, outf, sc, flip, cp);
        @(negedge clk);
        cfg_width = 9'(w); cfg_height = 11'(h); cfg_in_fmt = 3'(inf); cfg_out_fmt = 3'(outf);
        cfg_scale = 2'(sc); cfg_flip = flip[0]; cfg_copy = cp[0]; start = 1'b1;
        @(negedge clk);
        cfg_width = 9'd7; cfg_height = 11'd9; cfg_in_fmt = 3'(outf); cfg_out_fmt = 3'(inf);
        cfg_scale = 2'(sc + 1); cfg_flip = ~flip[0]; cfg_copy = ~cp[0];
        @(negedge clk);
        start = 1'b0;
        got = 0;
        fork
            begin : feeder
                int idx, cyc;
                idx = 0; cyc = 0;
                while (idx < n_src && cyc < 30000) begin
                    @(negedge clk);
                    cyc++;
                    in_valid = (((cyc + seed) % 4) != 3);
                    in_data  = src_b[idx];
                    #1;
                    if (in_valid && in_ready) idx++;
                end
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin : collector
                int cyc;
                cyc = 0;
                while (got < n_exp && cyc < 30000) begin
                    @(negedge clk);
                    cyc++;
                    out_ready = (((cyc * 7 + seed) % 5) != 0);
                    #1;
                    if (out_valid && out_ready) begin
                        chk(out_data == exp_b[got], req, int'(out_data), int'(exp_b[got]));
                        got++;
                    end
                end
            end
        join
        extra = 0; guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
            out_ready = 1'b1;
            #1;
            if (out_valid) extra++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(got == n_exp && extra == 0, {req, " R10 byte count"}, got + extra, n_exp);
        chk(!busy, "R11 busy falls", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int seed;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy && !out_valid && !in_ready, "R1 reset state",
            {busy, out_valid, in_ready}, 0);

        // R1: bytes offered while idle are not taken.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'(8'hA5 + i); out_ready = 1'b1;
            #1;
            chk(!in_ready && !out_valid && !busy, "R1 idle ignores input",
                {in_ready, out_valid, busy}, 0);
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;

        // R2 R3 R4 R5: every format pairing, unscaled.
        seed = 1;
        for (int fi = 0; fi < 5; fi++) begin
            for (int fo = 0; fo < 5; fo++) begin
                run_frame(3, 2, fi, fo, 0, 0, 0, seed, "R2 R3 R4 R5 format pair");
                seed++;
            end
        end

        // R5: mode 3 behaves as no scaling.
        run_frame(3, 3, 1, 2, 3, 0, 0, 40, "R5 mode3");
        // R8: plain vertical flip.
        run_frame(4, 4, 0, 0, 0, 1, 0, 41, "R8 flip");
        run_frame(2, 3, 3, 4, 0, 1, 0, 42, "R8 flip fmt");
        // R6: horizontal halving with odd width, with and without flip.
        run_frame(5, 2, 0, 0, 1, 0, 0, 43, "R6 halve x");
        run_frame(5, 2, 2, 3, 1, 1, 0, 44, "R6 R8 halve x flip");
        // R7: 2x2 halving with odd height, with and without flip.
        run_frame(4, 5, 0, 0, 2, 0, 0, 45, "R7 halve xy");
        run_frame(4, 5, 4, 1, 2, 1, 0, 46, "R7 R8 halve xy flip");
        run_frame(16, 8, 2, 4, 2, 1, 0, 47, "R7 R8 larger");
        run_frame(256, 2, 0, 0, 2, 0, 0, 48, "R7 max width");
        // R6: single column halves to nothing.
        run_frame(1, 2, 0, 0, 1, 0, 0, 49, "R6 empty output");
        // R9: raw copy for every input format, output format differs.
        for (int fi = 0; fi < 5; fi++) begin
            run_frame(3, 2, fi, (fi + 2) % 5, fi % 3, fi % 2, 1, 50 + fi, "R9 copy");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule